// File: doc/BRIEF.md
# Data Memory Access Router with Stretch Control

This block sits between a processor core and its data-space resources and handles one data-space access at a time. When a read or write request arrives while the block is idle, it latches the address, the direction, the mapping mode, the stretch value and the lock bits. It then decides where the access goes: to the 1 kB on-chip SRAM, to the external bus, to a read-only lock-status location, or to a blocked region that produces no bus activity. It then holds the chosen path active for a computed number of clocks.

The access window length is counted in machine cycles of four clocks. External transfers last two machine cycles plus the stretch value, so slow peripherals can be reached without glue logic. On-chip SRAM transfers, lock-status reads and blocked accesses always last two machine cycles. A single-clock completion pulse marks the last clock of every window. The registers that hold the mode and stretch fields live outside this block. Their reset values (mode 00, stretch 1) are applied there.

The controller has four states. The transitions are:
- IDLE → INT_ACC when the decode selects the SRAM.
- IDLE → EXT_ACC when the decode selects the external bus.
- IDLE → BLOCKED for a lock-status read, a status write or a reserved address.
- From any access state back to IDLE on the clock where the down-counter reaches zero, which is the clock `done` is high.

Top module: `dmr_router`

## Requirements
- R1: After reset the block is idle: `int_sel`=0, `int_we`=0, `ext_req`=0, `ext_rd_n`=1, `ext_wr_n`=1, `done`=0, `rdata`=00h.
- R2: With `mode`=00, every address 0000h–FFFFh is routed to the external bus (`ext_req`=1 for the window, `int_sel`=0).
- R3: With `mode`=01, addresses 0000h–03FFh are routed to the SRAM (`int_sel`=1) and 0400h–FFFFh to the external bus.
- R4: With `mode`=11, addresses 0000h–03FFh are routed to the SRAM. A read of FFFCh returns on `rdata` during `done` the byte {5'b00000, lock[2:0]}, with lock bit n on `rdata` bit n and bits 7–3 zero.
- R5: With `mode`=11, a write to FFFCh and any access to 0400h–FFFBh or FFFDh–FFFFh asserts neither `int_sel` nor `ext_req`, keeps both bus strobes high, lasts 8 clocks, and a read returns 00h.
- R6: With `mode`=10, every access behaves as a blocked access as in R5, and reads return 00h.
- R7: An external access window lasts (2 + `stretch`) × 4 clocks, 8 to 36 clocks, and `done` is high on its last clock only.
- R8: An SRAM access window lasts exactly 8 clocks for every `stretch` value.
- R9: During an external read `ext_rd_n`=0 and `ext_wr_n`=1 for the whole window; during an external write the reverse. During an SRAM window `int_we` equals the write direction and the bus strobes stay high. When `rd_req` and `wr_req` are both high, the access is a read.
- R10: Requests, and changes on `addr`, `mode`, `stretch` and `lock`, that occur while a window is open have no effect on that window. The block returns to idle after `done` without starting a new access.
- R11: `done` is a one-clock pulse, and `acc_addr` holds the accepted address for the whole window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request, sampled while idle |
| wr_req | input | 1 | Write request, sampled while idle |
| addr | input | 16 | Data-space address |
| mode | input | 2 | Address-map mode |
| stretch | input | 3 | Extra machine cycles for external transfers |
| lock | input | 3 | Lock bit state reported by the status location |
| int_sel | output | 1 | SRAM select for the window |
| int_we | output | 1 | SRAM write enable for the window |
| ext_req | output | 1 | External bus transfer in progress |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| acc_addr | output | 16 | Latched address of the open access |
| rdata | output | 8 | Status/blocked read data, 00h otherwise |
| done | output | 1 | Last clock of the access window |

## Verification
The case hardest to bring about from the ports is an input disturbance inside an open window. A second request, a different mode and a different stretch value must all arrive mid-window and still leave the window length and routing untouched. The bench reaches it with a directed access that raises both request lines and flips the mode and stretch fields on the second clock of a long external window. It then checks the length and the idle state after `done`. The narrow mode-11 corners are forced directly because random addresses rarely hit them: FFFCh read versus write, FFFBh, and 0400h. Random traffic biased toward the 03FFh/0400h boundary covers the other cases.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        TGT_EXT  = 2'd0,
        TGT_INT  = 2'd1,
        TGT_STAT = 2'd2,
        TGT_NULL = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_INT_ACC = 2'd1,
        ST_EXT_ACC = 2'd2,
        ST_BLOCKED = 2'd3
    } state_e;

endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
    import dmr_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          INT_BYTES   = 1024,
    parameter int unsigned STATUS_ADDR = 32'h0000_FFFC
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [MODE_W-1:0] mode,
    input  logic              is_wr,
    output target_e           tgt
);
    localparam int INT_AW = $clog2(INT_BYTES);

    logic in_low;
    logic at_status;

    always_comb begin
        in_low    = (addr >> INT_AW) == '0;
        at_status = addr == ADDR_W'(STATUS_ADDR);
        unique case (mode)
            2'b00: tgt = TGT_EXT;
            2'b01: tgt = in_low ? TGT_INT : TGT_EXT;
            2'b11: begin
                if (in_low)                 tgt = TGT_INT;
                else if (at_status && !is_wr) tgt = TGT_STAT;
                else                        tgt = TGT_NULL;
            end
            default: tgt = TGT_NULL;
        endcase
    end

endmodule

// File: rtl/dmr_length.sv
module dmr_length
    import dmr_pkg::*;
#(
    parameter int STRETCH_W   = 3,
    parameter int CLKS_PER_MC = 4,
    parameter int BASE_MC     = 2,
    parameter int CNT_W       = 6
) (
    input  target_e              tgt,
    input  logic [STRETCH_W-1:0] stretch,
    output logic [CNT_W-1:0]     clocks_m1
);
    int unsigned mc;

    always_comb begin
        unique case (tgt)
            TGT_EXT: mc = BASE_MC + int'(stretch);
            default: mc = BASE_MC;
        endcase
        clocks_m1 = CNT_W'(mc * CLKS_PER_MC - 1);
    end

endmodule

// File: rtl/dmr_status.sv
module dmr_status
    import dmr_pkg::*;
#(
    parameter int LOCK_W = 3,
    parameter int DATA_W = 8
) (
    input  target_e           tgt,
    input  logic [LOCK_W-1:0] lock,
    output logic [DATA_W-1:0] stat_byte
);
    logic show;
    assign show = tgt == TGT_STAT;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < LOCK_W) begin : g_lock
            assign stat_byte[i] = show & lock[i];
        end else begin : g_zero
            assign stat_byte[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dmr_router.sv
module dmr_router
    import dmr_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          INT_BYTES   = 1024,
    parameter int unsigned STATUS_ADDR = 32'h0000_FFFC,
    parameter int          STRETCH_W   = 3,
    parameter int          LOCK_W      = 3,
    parameter int          CLKS_PER_MC = 4,
    parameter int          BASE_MC     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [MODE_W-1:0]    mode,
    input  logic [STRETCH_W-1:0] stretch,
    input  logic [LOCK_W-1:0]    lock,
    output logic                 int_sel,
    output logic                 int_we,
    output logic                 ext_req,
    output logic                 ext_rd_n,
    output logic                 ext_wr_n,
    output logic [ADDR_W-1:0]    acc_addr,
    output logic [DATA_W-1:0]    rdata,
    output logic                 done
);
    localparam int MAX_CLKS = (BASE_MC + (1 << STRETCH_W) - 1) * CLKS_PER_MC;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam int MIN_CLKS = BASE_MC * CLKS_PER_MC;

    state_e              state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                wr_q;
    logic [DATA_W-1:0]   rdata_q;

    logic                accept;
    logic                dir_wr;
    target_e             tgt;
    logic [CNT_W-1:0]    len_m1;
    logic [DATA_W-1:0]   stat_byte;
    logic                last;

    assign accept = (state_q == ST_IDLE) && (rd_req || wr_req);
    assign dir_wr = wr_req && !rd_req;
    assign last   = (state_q != ST_IDLE) && (cnt_q == '0);

    dmr_decode #(
        .ADDR_W      (ADDR_W),
        .INT_BYTES   (INT_BYTES),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_decode (
        .addr  (addr),
        .mode  (mode),
        .is_wr (dir_wr),
        .tgt   (tgt)
    );

    dmr_length #(
        .STRETCH_W   (STRETCH_W),
        .CLKS_PER_MC (CLKS_PER_MC),
        .BASE_MC     (BASE_MC),
        .CNT_W       (CNT_W)
    ) u_length (
        .tgt       (tgt),
        .stretch   (stretch),
        .clocks_m1 (len_m1)
    );

    dmr_status #(
        .LOCK_W (LOCK_W),
        .DATA_W (DATA_W)
    ) u_status (
        .tgt       (tgt),
        .lock      (lock),
        .stat_byte (stat_byte)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (tgt)
                        TGT_EXT: state_d = ST_EXT_ACC;
                        TGT_INT: state_d = ST_INT_ACC;
                        default: state_d = ST_BLOCKED;
                    endcase
                end
            end
            ST_INT_ACC, ST_EXT_ACC, ST_BLOCKED: begin
                if (cnt_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q   <= len_m1;
                addr_q  <= addr;
                wr_q    <= dir_wr;
                rdata_q <= stat_byte;
            end else if (state_q != ST_IDLE && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        int_sel  = 1'b0;
        int_we   = 1'b0;
        ext_req  = 1'b0;
        ext_rd_n = 1'b1;
        ext_wr_n = 1'b1;
        rdata    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INT_ACC: begin
                int_sel = 1'b1;
                int_we  = wr_q;
            end
            ST_EXT_ACC: begin
                ext_req  = 1'b1;
                ext_rd_n = wr_q;
                ext_wr_n = !wr_q;
            end
            ST_BLOCKED: rdata = rdata_q;
            default: ;
        endcase
        done     = last;
        acc_addr = addr_q;
    end

    // window measurement for the length assertions
    logic [CNT_W-1:0]     win_q;
    logic [STRETCH_W-1:0] str_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            str_q <= '0;
        end else if (accept) begin
            win_q <= '0;
            str_q <= stretch;
        end else if (state_q != ST_IDLE) begin
            win_q <= win_q + 1'b1;
        end
    end

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n)); // R9
    AST_STROBE_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> ext_req); // R9
    AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_sel && ext_req)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_sel || ext_req) && !done) |=> $stable(acc_addr)); // R11
    AST_EXT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ext_req) |-> (int'(win_q) + 1 == (BASE_MC + int'(str_q)) * CLKS_PER_MC)); // R7
    AST_INT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && int_sel) |-> (int'(win_q) + 1 == MIN_CLKS)); // R8
    AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:LOCK_W] == '0); // R4

endmodule

// File: tb/dmr_router_test.sv
module dmr_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [15:0] addr = '0;
    logic [1:0]  mode = '0;
    logic [2:0]  stretch = 3'd1;
    logic [2:0]  lock = '0;
    logic        int_sel, int_we, ext_req, ext_rd_n, ext_wr_n, done;
    logic [15:0] acc_addr;
    logic [7:0]  rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dmr_router uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .addr(addr), .mode(mode), .stretch(stretch), .lock(lock),
        .int_sel(int_sel), .int_we(int_we), .ext_req(ext_req),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .acc_addr(acc_addr),
        .rdata(rdata), .done(done)
    );

    // 0 external, 1 internal, 2 status, 3 blocked
    function automatic int exp_kind(input logic [1:0] m, input logic [15:0] a, input bit w);
        bit low = a < 16'h0400;
        case (m)
            2'b00: return 0;
            2'b01: return low ? 1 : 0;
            2'b11: return low ? 1 : ((a == 16'hFFFC && !w) ? 2 : 3);
            default: return 3;
        endcase
    endfunction

    function automatic int exp_len(input int kind, input logic [2:0] s);
        return (kind == 0) ? (2 + int'(s)) * 4 : 8;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input bit w, input logic [1:0] m,
                          input logic [2:0] s, input logic [2:0] lk,
                          input bit both, input bit disturb);
        int kind, len, obs, route;
        bit strobe_ok, addr_ok, got_done;
        logic [7:0] rd_val, exp_rd;
        bit eff_w;
        eff_w = both ? 1'b0 : w;
        kind  = exp_kind(m, a, eff_w);
        len   = exp_len(kind, s);
        exp_rd = (kind == 2) ? {5'b0, lk} : 8'h00;
        @(negedge clk);
        addr = a; mode = m; stretch = s; lock = lk;
        rd_req = both | !w; wr_req = both | w;
        @(posedge clk);
        @(negedge clk);
        rd_req = 0; wr_req = 0;
        obs = 0; route = 3; strobe_ok = 1; addr_ok = 1; got_done = 0; rd_val = 8'h00;
        while (obs < 64) begin
            obs++;
            if (int_sel) route = 1;
            if (ext_req) route = 0;
            if (acc_addr != a) addr_ok = 0;
            case (kind)
                0: if (ext_rd_n != eff_w || ext_wr_n != !eff_w || int_sel) strobe_ok = 0;
                1: if (!ext_rd_n || !ext_wr_n || int_we != eff_w || ext_req) strobe_ok = 0;
                default: if (!ext_rd_n || !ext_wr_n || int_sel || ext_req) strobe_ok = 0;
            endcase
            if (done) begin
                rd_val = rdata; got_done = 1;
                break;
            end
            if (disturb && obs == 2) begin
                rd_req = 1; wr_req = 1; mode = ~m; stretch = ~s; lock = ~lk; addr = ~a;
            end else if (disturb && obs == 3) begin
                rd_req = 0; wr_req = 0; mode = m; stretch = s; lock = lk; addr = a;
            end
            @(negedge clk);
        end
        // R7 R8 R5: window length, done on last clock
        check(got_done && obs == len, kind == 0 ? "R7 length" : "R8/R5 length", obs, len);
        // R2 R3 R4 R6: routing
        check(route == (kind > 1 ? 3 : kind),
              m == 2'b10 ? "R6 route" : (m == 2'b11 ? "R4 route" : (m == 2'b01 ? "R3 route" : "R2 route")),
              route, kind > 1 ? 3 : kind);
        check(strobe_ok, "R9 strobes", 0, 1);
        check(addr_ok, "R11 acc_addr held", acc_addr, a);
        if (!eff_w) check(rd_val == exp_rd, kind == 2 ? "R4 status byte" : "R5 read data", rd_val, exp_rd);
        @(negedge clk);
        // R11 done is one clock; R10 no new access started
        check(!done && !int_sel && !ext_req, "R10/R11 idle after done",
              {done, int_sel, ext_req}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!int_sel && !int_we && !ext_req && ext_rd_n && ext_wr_n && !done && rdata == 0,
              "R1 reset outputs",
              {int_sel, int_we, ext_req, ext_rd_n, ext_wr_n, done}, 6'b000110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!int_sel && !ext_req && !done, "R1 idle after reset", {int_sel, ext_req, done}, 0);

        access(16'h0000, 0, 2'b00, 3'd0, 3'd0, 0, 0); // R2 R7 min stretch
        access(16'hFFFF, 1, 2'b00, 3'd7, 3'd0, 0, 0); // R2 R7 max stretch
        access(16'h03FF, 0, 2'b01, 3'd7, 3'd0, 0, 0); // R3 R8
        access(16'h0400, 1, 2'b01, 3'd1, 3'd0, 0, 0); // R3 boundary
        access(16'h0010, 1, 2'b01, 3'd5, 3'd0, 0, 0); // R8 R9 int write
        access(16'hFFFC, 0, 2'b11, 3'd6, 3'b101, 0, 0); // R4
        access(16'hFFFC, 0, 2'b11, 3'd2, 3'b010, 0, 0); // R4
        access(16'hFFFC, 1, 2'b11, 3'd4, 3'b111, 0, 0); // R5 status write
        access(16'hFFFB, 0, 2'b11, 3'd7, 3'b111, 0, 0); // R5
        access(16'hFFFD, 0, 2'b11, 3'd3, 3'b111, 0, 0); // R5
        access(16'h0400, 1, 2'b11, 3'd0, 3'b001, 0, 0); // R5
        access(16'h0000, 1, 2'b11, 3'd7, 3'b001, 0, 0); // R4 low internal
        access(16'h0000, 0, 2'b10, 3'd7, 3'b111, 0, 0); // R6
        access(16'hFFFC, 0, 2'b10, 3'd7, 3'b111, 0, 0); // R6
        access(16'h8000, 1, 2'b00, 3'd7, 3'd0, 1, 0);   // R9 both -> read
        access(16'h9000, 0, 2'b00, 3'd6, 3'd0, 0, 1);   // R10 disturb ext
        access(16'h0123, 1, 2'b01, 3'd0, 3'd0, 0, 1);   // R10 disturb int

        for (int i = 0; i < 150; i++) begin
            logic [15:0] a;
            int pick = $urandom_range(0, 3);
            case (pick)
                0: a = 16'h03F0 + 16'($urandom_range(0, 31));
                1: a = 16'hFFF8 + 16'($urandom_range(0, 7));
                default: a = 16'($urandom);
            endcase
            access(a, 1'($urandom), 2'($urandom), 3'($urandom), 3'($urandom),
                   ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) == 0));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule